// File: doc/BRIEF.md
# Endian-Selectable Pixel Word Unpacker

This block sits between a frame-buffer word fetcher and a display pipeline. It takes 32-bit memory words on a valid/ready input stream and hands out the pixels inside each word, one per beat, on a valid/ready output stream. Pixels may be 4, 8 or 16 bits wide. The 16-bit setting also carries palette entries. An ordering control sets which end of the word gives the first pixel. The control picks whole sub-word slices in turn and does not swap bytes.

In single-panel monochrome mode the pixels are 1 bit wide. The block then groups them for the panel data pins, four per beat or, with the wide-pin control set, eight per beat. The wide-pin control has no effect outside this mode. All controls are captured together with each word, so a word is always split with one consistent setting.

Internally a two-state machine runs the stream. In `ST_EMPTY` no word is held and the input is ready. A word handshake takes the *LOAD* transition to `ST_HOLD`. In `ST_HOLD` the output is valid. An accepted pixel that is not the last of its word takes the *STEP* transition, which stays in `ST_HOLD` with the slice index advanced. An accepted last pixel takes one of two transitions. *RELOAD* stays in `ST_HOLD` when a new word is accepted in the same cycle. *DRAIN* returns to `ST_EMPTY` when no new word arrives. An output that is not accepted takes *WAIT*, which holds everything.

Top module: `pixel_word_unpacker`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `in_ready` is 1. The captured controls reset to little-endian order, 4-bit pixels, monochrome off and wide-pin off.
- R2: `cfg_pix_size` selects the pixel width: 2'b00 is 4 bits (8 pixels per word), 2'b01 is 8 bits (4 per word), and 2'b10 or 2'b11 is 16 bits (2 per word). Each pixel is zero-extended onto `out_data[15:0]`.
- R3: With `cfg_big_endian` = 0, the first pixel of a word comes from its least significant slice, and each later pixel comes from the next slice up.
- R4: With `cfg_big_endian` = 1, the first pixel of a word comes from its most significant slice, and each later pixel comes from the next slice down.
- R5: 16-bit data, which includes palette entries, follows the same rule. The low half-word (bits 15:0) comes out first in little-endian order, and the high half-word (bits 31:16) comes out first in big-endian order.
- R6: With `cfg_mono` = 1 and `cfg_wide_pins` = 0, each beat carries four 1-bit pixels on `out_data[3:0]`, taken as one 4-bit word slice. `out_data[15:4]` is 0, and a word gives 8 beats in the order set by R3/R4.
- R7: With `cfg_mono` = 1 and `cfg_wide_pins` = 1, each beat carries eight 1-bit pixels on `out_data[7:0]`, taken as one byte slice. `out_data[15:8]` is 0, and a word gives 4 beats.
- R8: With `cfg_mono` = 0, `cfg_wide_pins` has no effect on the output stream.
- R9: All controls are sampled in the cycle a word is accepted. Changing them while a word is being unpacked has no effect on that word.
- R10: `in_ready` is 1 only when no pixel is pending, or when the last pixel of the held word is accepted in that same cycle. A word is taken when `in_valid` and `in_ready` are both 1.
- R11: Once `out_valid` is 1, it stays 1 and `out_data` stays unchanged until `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | 1: most significant slice first; 0: least significant first |
| cfg_mono | input | 1 | Single-panel monochrome pin-group mode |
| cfg_wide_pins | input | 1 | Monochrome only: 1 for 8-pin groups, 0 for 4-pin groups |
| cfg_pix_size | input | 2 | Pixel width code (00: 4, 01: 8, 1x: 16 bits) |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Frame-buffer word |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | Output pixel or pin group valid |
| out_data | output | 16 | Pixel or pin group, zero-extended |
| out_ready | input | 1 | Downstream accepts the output this cycle |

## Verification
The bench randomizes both handshakes, so words arrive back to back as well as with gaps. This exercises the *RELOAD* path, where a design that stalled a cycle or dropped the incoming word would show a wrong `in_ready` or a missing pixel sequence. Each width is run in both orders. A design that swapped bytes instead of ordering slices, or that started 16-bit words from the wrong half, would miscompare on the first pixel of nearly every word. In one phase the controls are scrambled every cycle. A design that read them live instead of capturing them with the word would mix orderings inside a word. Non-monochrome runs with the wide-pin control set would show any leak of that control into the pixel width. Long stretches with downstream not ready would expose data that changed during a stall.

// File: rtl/pu_pkg.sv
package pu_pkg;

    // slice width chosen for the word currently held
    typedef enum logic [1:0] {
        SLICE_NIB  = 2'd0,
        SLICE_BYTE = 2'd1,
        SLICE_HALF = 2'd2
    } slice_e;

    // handshake state machine
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } state_e;

    // controls captured together with each word
    typedef struct packed {
        logic       big_endian;
        logic       mono;
        logic       wide_pins;
        logic [1:0] pix_size;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{big_endian: 1'b0, mono: 1'b0,
                                   wide_pins: 1'b0, pix_size: 2'b00};

endpackage

// File: rtl/pu_slice_decode.sv
module pu_slice_decode
    import pu_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int NIB_N  = WORD_W / 4,
    localparam int BYTE_N = WORD_W / 8,
    localparam int HALF_N = WORD_W / 16,
    localparam int IDX_W  = $clog2(NIB_N)
) (
    input  cfg_t             cfg,
    output slice_e           slice,
    output logic [IDX_W-1:0] last_idx
);

    // monochrome mode groups 1-bit pixels by pin count; otherwise the
    // pixel size picks the slice and the wide-pin control is not used
    always_comb begin
        if (cfg.mono) begin
            slice = cfg.wide_pins ? SLICE_BYTE : SLICE_NIB;
        end else begin
            unique case (cfg.pix_size)
                2'b00:   slice = SLICE_NIB;
                2'b01:   slice = SLICE_BYTE;
                default: slice = SLICE_HALF;
            endcase
        end
    end

    always_comb begin
        unique case (slice)
            SLICE_NIB:  last_idx = IDX_W'(NIB_N - 1);
            SLICE_BYTE: last_idx = IDX_W'(BYTE_N - 1);
            default:    last_idx = IDX_W'(HALF_N - 1);
        endcase
    end

endmodule

// File: rtl/pu_word_slicer.sv
module pu_word_slicer
    import pu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OUT_W  = 16,
    localparam int NIB_N  = WORD_W / 4,
    localparam int BYTE_N = WORD_W / 8,
    localparam int HALF_N = WORD_W / 16,
    localparam int IDX_W  = $clog2(NIB_N),
    localparam int BPOS_W = $clog2(BYTE_N),
    localparam int HPOS_W = $clog2(HALF_N)
) (
    input  logic [WORD_W-1:0] word,
    input  slice_e            slice,
    input  logic              big_endian,
    input  logic [IDX_W-1:0]  idx,
    output logic [OUT_W-1:0]  pix
);

    logic [3:0]  nib_a  [NIB_N];
    logic [7:0]  byte_a [BYTE_N];
    logic [15:0] half_a [HALF_N];

    // break the word into its slices once for each width
    for (genvar gn = 0; gn < NIB_N; gn++) begin : g_nib
        assign nib_a[gn] = word[gn*4 +: 4];
    end
    for (genvar gb = 0; gb < BYTE_N; gb++) begin : g_byte
        assign byte_a[gb] = word[gb*8 +: 8];
    end
    for (genvar gh = 0; gh < HALF_N; gh++) begin : g_half
        assign half_a[gh] = word[gh*16 +: 16];
    end

    // the beat index counts up in both orders; big-endian mirrors it
    logic [IDX_W-1:0]  pos_n;
    logic [BPOS_W-1:0] pos_b;
    logic [HPOS_W-1:0] pos_h;

    always_comb begin
        pos_n = big_endian ? (IDX_W'(NIB_N - 1) - idx) : idx;
        pos_b = big_endian ? (BPOS_W'(BYTE_N - 1) - idx[BPOS_W-1:0])
                           : idx[BPOS_W-1:0];
        pos_h = big_endian ? (HPOS_W'(HALF_N - 1) - idx[HPOS_W-1:0])
                           : idx[HPOS_W-1:0];
    end

    always_comb begin
        unique case (slice)
            SLICE_NIB:  pix = OUT_W'(nib_a[pos_n]);
            SLICE_BYTE: pix = OUT_W'(byte_a[pos_b]);
            default:    pix = OUT_W'(half_a[pos_h]);
        endcase
    end

endmodule

// File: rtl/pu_unpack_fsm.sv
module pu_unpack_fsm
    import pu_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [IDX_W-1:0] last_idx,
    output logic             in_ready,
    output logic             out_valid,
    output logic             load,
    output logic [IDX_W-1:0] idx
);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] idx_d;
    logic             at_last;

    assign at_last = (idx == last_idx);

    // next state and beat index
    always_comb begin
        state_d = state_q;
        idx_d   = idx;
        unique case (state_q)
            ST_EMPTY: begin
                if (load) begin                 // LOAD
                    state_d = ST_HOLD;
                    idx_d   = '0;
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    if (!at_last) begin         // STEP
                        idx_d = idx + 1'b1;
                    end else if (load) begin    // RELOAD
                        idx_d = '0;
                    end else begin              // DRAIN
                        state_d = ST_EMPTY;
                        idx_d   = '0;
                    end
                end                             // WAIT otherwise
            end
            default: begin
                state_d = ST_EMPTY;
                idx_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            idx     <= '0;
        end else begin
            state_q <= state_d;
            idx     <= idx_d;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: in_ready = 1'b1;
            ST_HOLD: begin
                out_valid = 1'b1;
                in_ready  = out_ready && at_last;
            end
            default: ;
        endcase
        load = in_valid && in_ready;
    end

endmodule

// File: rtl/pixel_word_unpacker.sv
module pixel_word_unpacker
    import pu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OUT_W  = 16,
    localparam int NIB_N = WORD_W / 4,
    localparam int IDX_W = $clog2(NIB_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic              cfg_mono,
    input  logic              cfg_wide_pins,
    input  logic [1:0]        cfg_pix_size,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    input  logic              out_ready
);

    cfg_t              cfg_q;
    logic [WORD_W-1:0] word_q;
    slice_e            slice;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  idx;
    logic              load;

    // controls and data are captured only with a word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET;
            word_q <= '0;
        end else if (load) begin
            cfg_q  <= '{big_endian: cfg_big_endian, mono: cfg_mono,
                        wide_pins: cfg_wide_pins, pix_size: cfg_pix_size};
            word_q <= in_word;
        end
    end

    pu_slice_decode #(.WORD_W(WORD_W)) u_decode (
        .cfg      (cfg_q),
        .slice    (slice),
        .last_idx (last_idx)
    );

    pu_unpack_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .last_idx  (last_idx),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .idx       (idx)
    );

    pu_word_slicer #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_slicer (
        .word       (word_q),
        .slice      (slice),
        .big_endian (cfg_q.big_endian),
        .idx        (idx),
        .pix        (out_data)
    );

endmodule

// File: rtl/pu_checker.sv
module pu_checker
    import pu_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input cfg_t             lat_cfg
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid && !out_ready));

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(in_valid && in_ready)) |=> $stable(lat_cfg));

    assert_narrow_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lat_cfg.mono && !lat_cfg.wide_pins) |-> (out_data[OUT_W-1:4] == '0));

    assert_wide_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lat_cfg.mono) |-> (out_data[OUT_W-1:8] == '0));

    assert_nibble_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !lat_cfg.mono && lat_cfg.pix_size == 2'b00) |-> (out_data[OUT_W-1:4] == '0));

endmodule

bind pixel_word_unpacker pu_checker #(.OUT_W(OUT_W)) u_pu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .lat_cfg   (cfg_q)
);

// File: tb/tb_pixel_word_unpacker.sv
module tb_pixel_word_unpacker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        cfg_mono = 1'b0;
    logic        cfg_wide_pins = 1'b0;
    logic [1:0]  cfg_pix_size = 2'b00;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    pixel_word_unpacker dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_big_endian (cfg_big_endian),
        .cfg_mono       (cfg_mono),
        .cfg_wide_pins  (cfg_wide_pins),
        .cfg_pix_size   (cfg_pix_size),
        .in_valid       (in_valid),
        .in_word        (in_word),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_ready      (out_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_for(bit big, bit mono, bit wide, logic [1:0] sz, bit scrambled);
        if (scrambled)          return "R9";
        if (mono)               return wide ? "R7" : "R6";
        if (wide)               return "R8";
        if (sz[1])              return "R5";
        if (sz == 2'b01)        return "R2";
        return big ? "R4" : "R3";
    endfunction

    // behavioural model: expand a word into its expected beats
    task automatic push_word(input logic [31:0] w, input bit big, input bit mono,
                             input bit wide, input logic [1:0] sz, input bit scrambled);
        int width;
        int cnt;
        logic [31:0] mask;
        if (mono)              width = wide ? 8 : 4;
        else if (sz == 2'b00)  width = 4;
        else if (sz == 2'b01)  width = 8;
        else                   width = 16;
        cnt  = 32 / width;
        mask = (32'h1 << width) - 32'h1;
        for (int k = 0; k < cnt; k++) begin
            int p;
            logic [31:0] v;
            p = big ? (cnt - 1 - k) : k;
            v = (w >> (p * width)) & mask;
            exp_q.push_back(v[15:0]);
            tag_q.push_back(tag_for(big, mono, wide, sz, scrambled));
        end
    endtask

    // one cycle: drive at the falling edge, compare just after, model the edge
    task automatic cycle(input int vin_pct, input int rdy_pct, input bit scramble);
        bit exp_ir;
        @(negedge clk);
        in_valid  = (($urandom % 100) < vin_pct);
        in_word   = $urandom;
        out_ready = (($urandom % 100) < rdy_pct);
        if (scramble) begin
            cfg_big_endian = $urandom % 2;
            cfg_mono       = $urandom % 2;
            cfg_wide_pins  = $urandom % 2;
            cfg_pix_size   = $urandom % 4;
        end
        #1;
        exp_ir = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready);
        check("R11 out_valid", {31'b0, out_valid}, {31'b0, exp_q.size() > 0});
        check("R10 in_ready", {31'b0, in_ready}, {31'b0, exp_ir});
        if (out_valid && exp_q.size() > 0)
            check({tag_q[0], " out_data"}, {16'b0, out_data}, {16'b0, exp_q[0]});
        if (out_valid && out_ready && exp_q.size() > 0) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        if (in_valid && exp_ir)
            push_word(in_word, cfg_big_endian, cfg_mono, cfg_wide_pins, cfg_pix_size, scramble);
    endtask

    task automatic phase(input bit big, input bit mono, input bit wide,
                         input logic [1:0] sz, input int n, input int vin_pct, input int rdy_pct);
        // let the previous setting drain before changing controls
        while (exp_q.size() > 0) cycle(0, 100, 1'b0);
        @(negedge clk);
        cfg_big_endian = big;
        cfg_mono       = mono;
        cfg_wide_pins  = wide;
        cfg_pix_size   = sz;
        for (int i = 0; i < n; i++) cycle(vin_pct, rdy_pct, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset in_ready", {31'b0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 post-reset out_valid", {31'b0, out_valid}, 32'd0);

        // reset controls: little-endian nibbles (R1, R3)
        for (int i = 0; i < 300; i++) cycle(70, 70, 1'b0);
        phase(1'b1, 1'b0, 1'b0, 2'b00, 400, 70, 70);    // R4 nibbles
        phase(1'b0, 1'b0, 1'b0, 2'b01, 400, 80, 60);    // R2 bytes
        phase(1'b1, 1'b0, 1'b0, 2'b01, 400, 80, 60);
        phase(1'b0, 1'b0, 1'b0, 2'b10, 400, 90, 90);    // R5 halves
        phase(1'b1, 1'b0, 1'b0, 2'b10, 400, 90, 90);
        phase(1'b0, 1'b0, 1'b0, 2'b11, 300, 60, 80);
        phase(1'b1, 1'b0, 1'b0, 2'b11, 300, 60, 80);
        phase(1'b0, 1'b1, 1'b0, 2'b10, 400, 70, 70);    // R6
        phase(1'b1, 1'b1, 1'b0, 2'b01, 400, 70, 70);
        phase(1'b0, 1'b1, 1'b1, 2'b00, 400, 70, 70);    // R7
        phase(1'b1, 1'b1, 1'b1, 2'b10, 400, 70, 70);
        phase(1'b0, 1'b0, 1'b1, 2'b00, 300, 70, 70);    // R8
        phase(1'b1, 1'b0, 1'b1, 2'b01, 300, 70, 70);
        phase(1'b0, 1'b0, 1'b1, 2'b10, 300, 70, 70);
        phase(1'b0, 1'b0, 1'b0, 2'b00, 300, 100, 100);  // back-to-back RELOAD
        phase(1'b1, 1'b0, 1'b0, 2'b01, 300, 100, 20);   // long stalls, R11
        while (exp_q.size() > 0) cycle(0, 100, 1'b0);
        for (int i = 0; i < 1500; i++) cycle(70, 70, 1'b1);  // R9 scrambled controls
        while (exp_q.size() > 0) cycle(0, 100, 1'b0);
        cycle(0, 100, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule